// File: doc/BRIEF.md
# Cascaded Enable-Chained Clock Divider

This block slows a fast system clock (about 25.175 MHz) down to two visible rates near 1 Hz and 2 Hz. It does this with one wide binary count that is split into counter stages of at most 16 bits. Every stage runs on the same system clock. A stage advances only when all stages below it sit at their all-ones value, and each stage passes that condition upward as a terminal-count flag. No stage output ever drives another stage's clock.

The slow square wave is one chosen bit of the combined count. The faster square wave is the bit just below it, so the two stay locked in phase. Each square wave also has a tick that lasts one system cycle on its rising transition, which downstream logic can use as a clock enable. An asynchronous reset clears everything. A global enable freezes the whole count while it is low. The total width, the stage width and the tap position are parameters, so a small configuration can be used to check the divide ratio exactly.

Top module: `cascade_clkdiv`

## Requirements
- R1: While `rst` is high, every stage count is zero, and all outputs (`slow_sq`, `fast_sq`, `slow_tick`, `fast_tick`, `stage_tc`) are 0.
- R2: On each clock edge where `en` is high, the combined count (stage 0 is the least significant slice) increases by one and wraps to zero after all ones. `slow_sq` equals count bit `SLOW_TAP-1`, with bits numbered from 0.
- R3: `fast_sq` equals count bit `SLOW_TAP-2`. It rises exactly twice in each period of `slow_sq`, and it falls on the same edge where `slow_sq` rises.
- R4: `stage_tc[i]` is high exactly when stage i holds its all-ones value and its own enable is high. The enable of stage 0 is `en`. The enable of stage i is `stage_tc[i-1]`.
- R5: A stage above stage 0 increments only on an edge where `stage_tc` of the stage below is high.
- R6: While `en` is low, the count holds, both square waves hold their values, and `stage_tc` is all zero.
- R7: `slow_tick` (or `fast_tick`) is high for exactly one cycle: the first cycle in which `slow_sq` (or `fast_sq`) is high after being low.
- R8: With `en` held high, consecutive `slow_tick` pulses are exactly 2^`SLOW_TAP` cycles apart. The first one comes 2^(`SLOW_TAP`-1) enabled edges after reset.
- R9: Raising `rst` clears all outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared by every stage |
| rst | input | 1 | Asynchronous active-high reset |
| en | input | 1 | Global count enable |
| slow_sq | output | 1 | Square wave taken from count bit SLOW_TAP-1 (about 1 Hz) |
| fast_sq | output | 1 | Square wave taken from count bit SLOW_TAP-2 (about 2 Hz) |
| slow_tick | output | 1 | One-cycle pulse on each rise of slow_sq |
| fast_tick | output | 1 | One-cycle pulse on each rise of fast_sq |
| stage_tc | output | NSTG | Terminal-count flag of each stage, with stage 0 at bit 0 |

## Verification
The bench drives a configuration whose top stage is narrower than the others, and checks the carry from one stage to the next at every boundary. A design that chains stages on the count value alone, ignoring the enable, would raise `stage_tc` or carry upward while `en` is low. A design that is off by one in the chain would advance the upper stage one cycle early or late, which moves the square-wave edges. The bench parks the count at 15 with the enable low, measures the exact gap between ticks, and raises reset between clock edges. These steps catch a tick that lasts two cycles, a wrong tap bit, and a reset that waits for a clock.

// File: rtl/div_pkg.sv
package div_pkg;

  // number of stages needed to cover a total width
  function automatic int num_stages(input int total_w, input int stage_w);
    return (total_w + stage_w - 1) / stage_w;
  endfunction

  // least significant bit of stage idx within the combined count
  function automatic int stage_lsb(input int idx, input int stage_w);
    return idx * stage_w;
  endfunction

  // width of stage idx; the last stage takes whatever bits remain
  function automatic int stage_width(input int idx, input int total_w, input int stage_w);
    int rem;
    rem = total_w - idx * stage_w;
    return (rem < stage_w) ? rem : stage_w;
  endfunction

  // number of enabled cycles in one period of a square wave taken at 1-based bit n
  function automatic longint tap_period(input int n);
    return longint'(1) << n;
  endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  output logic [W-1:0] q,
  output logic         ceo
);
  logic at_max;

  assign at_max = (q == {W{1'b1}});
  assign ceo    = ce & at_max;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (ce) q <= q + 1'b1;
  end
endmodule

// File: rtl/div_tap.sv
module div_tap #(
  parameter int CW  = 25,
  parameter int BIT = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output logic          sq,
  output logic          tick
);
  logic sq_prev;

  assign sq   = cnt[BIT];
  assign tick = sq & ~sq_prev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sq_prev <= 1'b0;
    else     sq_prev <= sq;
  end
endmodule

// File: rtl/cascade_clkdiv.sv
module cascade_clkdiv #(
  parameter int TOTAL_W  = 25,
  parameter int STAGE_W  = 16,
  parameter int SLOW_TAP = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic slow_sq,
  output logic fast_sq,
  output logic slow_tick,
  output logic fast_tick,
  output logic [div_pkg::num_stages(TOTAL_W, STAGE_W)-1:0] stage_tc
);
  localparam int NSTG     = div_pkg::num_stages(TOTAL_W, STAGE_W);
  localparam int SLOW_BIT = SLOW_TAP - 1;
  localparam int FAST_BIT = SLOW_TAP - 2;

  logic [TOTAL_W-1:0] count_all;
  logic [NSTG:0]      chain_en;

  assign chain_en[0] = en;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int LSB = div_pkg::stage_lsb(g, STAGE_W);
    localparam int SW  = div_pkg::stage_width(g, TOTAL_W, STAGE_W);
    logic [SW-1:0] q_s;
    logic          ceo_s;
    div_stage #(.W(SW)) u_stage (
      .clk(clk), .rst(rst), .ce(chain_en[g]), .q(q_s), .ceo(ceo_s)
    );
    assign count_all[LSB +: SW] = q_s;
    assign chain_en[g+1]        = ceo_s;
    assign stage_tc[g]          = ceo_s;
  end

  div_tap #(.CW(TOTAL_W), .BIT(SLOW_BIT)) u_slow (
    .clk(clk), .rst(rst), .cnt(count_all), .sq(slow_sq), .tick(slow_tick)
  );
  div_tap #(.CW(TOTAL_W), .BIT(FAST_BIT)) u_fast (
    .clk(clk), .rst(rst), .cnt(count_all), .sq(fast_sq), .tick(fast_tick)
  );
endmodule

// File: rtl/cascade_clkdiv_chk.sv
module cascade_clkdiv_chk #(
  parameter int TOTAL_W  = 25,
  parameter int STAGE_W  = 16,
  parameter int SLOW_TAP = 25,
  parameter int NSTG     = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            slow_sq,
  input logic            fast_sq,
  input logic            slow_tick,
  input logic            fast_tick,
  input logic [NSTG-1:0] stage_tc
);
  localparam longint PER = div_pkg::tap_period(SLOW_TAP);

  logic              seen;
  logic [SLOW_TAP:0] gap;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (slow_tick) begin
      seen <= 1'b1;
      gap  <= {{SLOW_TAP{1'b0}}, en};
    end else begin
      gap  <= gap + {{SLOW_TAP{1'b0}}, en};
    end
  end

  // R7
  slow_tick_edge_chk: assert property (@(posedge clk) disable iff (rst)
    slow_tick |-> (slow_sq && !$past(slow_sq)));
  // R7
  fast_tick_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fast_tick |-> (fast_sq && !$past(fast_sq)));
  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(slow_sq) && $stable(fast_sq)));
  // R6
  tc_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (stage_tc == '0));
  // R3
  fast_falls_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_sq) |-> $fell(fast_sq));
  // R8
  slow_period_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && slow_tick) |-> (longint'(gap) == PER));

  for (genvar g = 1; g < NSTG; g++) begin : g_chain
    // R4
    tc_chain_chk: assert property (@(posedge clk) disable iff (rst)
      stage_tc[g] |-> stage_tc[g-1]);
  end
endmodule

bind cascade_clkdiv cascade_clkdiv_chk #(
  .TOTAL_W(TOTAL_W), .STAGE_W(STAGE_W), .SLOW_TAP(SLOW_TAP), .NSTG(NSTG)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .slow_sq(slow_sq), .fast_sq(fast_sq),
  .slow_tick(slow_tick), .fast_tick(fast_tick), .stage_tc(stage_tc)
);

// File: tb/cascade_clkdiv_tb.sv
module cascade_clkdiv_tb;
  localparam int TW = 10, SW = 4, TAP = 10, NS = 3;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic slow_sq, fast_sq, slow_tick, fast_tick;
  logic [NS-1:0] stage_tc;
  int tests = 0, fails = 0;

  cascade_clkdiv #(.TOTAL_W(TW), .STAGE_W(SW), .SLOW_TAP(TAP)) u_dut (
    .clk(clk), .rst(rst), .en(en), .slow_sq(slow_sq), .fast_sq(fast_sq),
    .slow_tick(slow_tick), .fast_tick(fast_tick), .stage_tc(stage_tc)
  );

  always #5 clk = ~clk;

  // independent reference: the count and the previous values of the tapped bits
  logic [TW-1:0] rc;
  logic ps, pf;
  always @(posedge clk or posedge rst) begin
    if (rst) begin rc <= '0; ps <= 1'b0; pf <= 1'b0; end
    else begin
      ps <= rc[TAP-1]; pf <= rc[TAP-2];
      if (en) rc <= rc + 1'b1;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [NS-1:0] etc;
    etc[0] = en & (rc[3:0] == 4'hF);
    etc[1] = etc[0] & (rc[7:4] == 4'hF);
    etc[2] = etc[1] & (rc[9:8] == 2'h3);
    chk("R2 slow_sq", slow_sq, rc[TAP-1]);
    chk("R3 fast_sq", fast_sq, rc[TAP-2]);
    chk("R4 stage_tc", stage_tc, etc);
    chk("R7 slow_tick", slow_tick, rc[TAP-1] & ~ps);
    chk("R7 fast_tick", fast_tick, rc[TAP-2] & ~pf);
  endtask

  task automatic step(input logic e);
    @(negedge clk);
    en = e;
    #1 check_all();
  endtask

  // segments: {enable, cycles}; covers the park at 15 with enable low (R5, R6) and full wraps
  localparam int NV = 8;
  localparam int VEC [NV][2] = '{
    '{1, 15}, '{0, 5}, '{1, 1}, '{1, 240}, '{0, 7}, '{1, 1}, '{1, 1100}, '{1, 1200}
  };

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t_first, t_second, nfast;
    logic s0, f0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {slow_sq, fast_sq, slow_tick, fast_tick, stage_tc}, 0);
    @(negedge clk); rst = 1'b0;

    // R2 R3 R4 R5 R6 R7 table walk
    for (int v = 0; v < NV; v++)
      for (int c = 0; c < VEC[v][1]; c++) step(VEC[v][0] != 0);

    // R6 explicit freeze
    s0 = slow_sq; f0 = fast_sq;
    repeat (40) step(1'b0);
    chk("R6 slow hold", slow_sq, s0);
    chk("R6 fast hold", fast_sq, f0);
    chk("R6 tc zero", stage_tc, 0);

    // R9 asynchronous reset between edges
    step(1'b1);
    #2 rst = 1'b1;
    #1;
    chk("R9 async clear", {slow_sq, fast_sq, slow_tick, fast_tick, stage_tc}, 0);
    @(negedge clk); rst = 1'b0;

    // R8 tick spacing and R3 fast ticks per slow period
    t_first = -1; t_second = -1; nfast = 0;
    for (int c = 1; c <= 2 * 1024 + 10 && t_second < 0; c++) begin
      step(1'b1);
      if (slow_tick && t_first < 0) t_first = c;
      else if (slow_tick) t_second = c;
      if (t_first >= 0 && t_second < 0 && fast_tick) nfast++;
    end
    chk("R8 first slow tick", t_first, 512);
    chk("R8 tick gap", t_second - t_first, 1024);
    chk("R3 fast ticks per slow period", nfast, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule